// File: doc/BRIEF.md
# Streaming Packet Transmit Queue

This block buffers outgoing packet bytes between a host byte-write port and a serializing transmitter. Packets may be longer than the queue, so the host keeps writing while bytes drain. Two programmable level alarms tell the host when to pause and when to resume writing. An upper alarm warns that the queue is close to full, and a lower alarm, which can be switched off, asks for more bytes. Overruns and underruns are flagged. Every alarm and event sits in a sticky interrupt vector, and the host clears its bits by writing ones.

A packet is launched in one of two ways: by a start command, or automatically in fast-start mode once enough bytes have been written. The controller takes exactly the packet length minus the CRC length from the queue, marks the final byte, and then raises a completion interrupt. Bytes written beyond the payload stay in the queue and are not sent. The host drops them with a stop command and then a flush. The controller is a four-state machine:
- IDLE goes to SEND on a start command or fast-start trigger, or to FINISH straight away when the payload is zero.
- SEND goes to FINISH after the last payload byte is handed over, to FAULT when the transmitter asks for a byte from an empty queue, and back to IDLE on the stop command.
- FINISH and FAULT each last one cycle and then return to IDLE.

Top module: `pkt_txq`

## Requirements
- R1: After reset the interrupt vector `irq` is all zero and `tx_valid` is low.
- R2: Bytes reach `tx_data` in write order. In SEND, `tx_valid` is high while the queue holds at least one byte, and a byte is consumed on a cycle with `tx_valid` and `tx_ready` both high.
- R3: `irq[0]` (upper alarm) is set one edge after the registered fill count first reaches `lvl_hi` or more. It is set again only after the count has dropped below `lvl_hi` and then risen to it once more.
- R4: `irq[1]` (lower alarm) is set one edge after the condition "`lvl_lo_en` high and fill count at most `lvl_lo`" becomes true. It is set only on that transition, and never while `lvl_lo_en` is low.
- R5: A write while the queue holds DEPTH bytes is discarded, and `irq[4]` is set on the same edge.
- R6: A `cmd_start` pulse in IDLE moves the controller to SEND on that edge.
- R7: When `fast_en` is high in IDLE, the controller moves to SEND one edge after the count of bytes accepted for the current packet first exceeds `lvl_lo` + 1.
- R8: The payload is `pkt_len` − `crc_len`, or zero if `crc_len` ≥ `pkt_len`. Exactly that many bytes are sent. `tx_last` is high with the final byte, and bytes left over are not sent.
- R9: `irq[2]` (packet done) is set one edge after the controller leaves SEND following the last payload byte.
- R10: `irq[3]` (payload accepted) is set on the edge that accepts the write bringing the packet's write count up to the payload.
- R11: If `tx_ready` is high in SEND while the queue is empty, the packet is aborted. The controller goes through FAULT to IDLE, `irq[5]` is set one edge after FAULT is entered, and nothing more is sent until the next start.
- R12: Writing 1 to a bit of `irq_clr` clears that bit of `irq`. When an event and a clear fall on the same cycle, the bit stays set.
- R13: `cmd_flush` empties the queue only in IDLE and is ignored in every other state. `cmd_off` in SEND returns the controller to IDLE without a done interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_vld | input | 1 | Host byte write strobe |
| wr_byte | input | 8 | Host write data |
| lvl_hi | input | 7 | Upper alarm level (fill count) |
| lvl_lo | input | 6 | Lower alarm level and fast-start base |
| lvl_lo_en | input | 1 | Enables the lower alarm |
| fast_en | input | 1 | Enables automatic start |
| pkt_len | input | 11 | Packet length field including CRC |
| crc_len | input | 3 | CRC length in bytes |
| cmd_start | input | 1 | Start pulse |
| cmd_off | input | 1 | Stop pulse; aborts a packet in SEND |
| cmd_flush | input | 1 | Empty the queue, honoured only in IDLE |
| irq_clr | input | 6 | Write-one-to-clear mask for `irq` |
| irq | output | 6 | Sticky interrupts: 0 upper, 1 lower, 2 done, 3 accepted, 4 overrun, 5 underrun |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes a byte |
| tx_data | output | 8 | Byte offered |
| tx_last | output | 1 | Final payload byte marker |

## Verification
- A write changes the fill count on the edge that captures it, and the overrun and accepted flags appear on that same edge.
- The two level alarms appear one edge after the count crosses its level. A start or fast-start trigger takes one edge to reach SEND.
- The done flag appears two edges after the last handshake, and the underrun flag two edges after the empty request.
- The bench drives every input 1 ns after a rising edge, reads outputs 1 ns after the next edge, and checks each flag at its due edge, after first confirming it is still low one edge earlier wherever that matters.

// File: rtl/pkt_txq_pkg.sv
package pkt_txq_pkg;
    // interrupt vector layout
    localparam int IRQ_N        = 6;
    localparam int IRQ_LVL_HI   = 0;
    localparam int IRQ_LVL_LO   = 1;
    localparam int IRQ_DONE     = 2;
    localparam int IRQ_ACCEPT   = 3;
    localparam int IRQ_OVERRUN  = 4;
    localparam int IRQ_UNDERRUN = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_FINISH = 2'd2,
        ST_FAULT  = 2'd3
    } txq_state_e;
endpackage

// File: rtl/txq_store.sv
// Circular byte store with registered fill count. DEPTH must be a power of two.
module txq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int FW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] pop_data,
    output logic [FW-1:0]     fill,
    output logic              empty,
    output logic              full,
    output logic              push_ok
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              pop_ok;

    assign empty    = (fill == '0);
    assign full     = (fill == FW'(DEPTH));
    assign push_ok  = push_req && !full && !flush;
    assign pop_ok   = pop && !empty && !flush;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            fill <= fill + FW'(push_ok) - FW'(pop_ok);
        end
    end
endmodule

// File: rtl/txq_level.sv
// Level comparators on the registered fill count, reporting entry edges only.
module txq_level #(
    parameter int FW   = 7,
    parameter int LO_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FW-1:0]   fill,
    input  logic [FW-1:0]   hi_thr,
    input  logic [LO_W-1:0] lo_thr,
    input  logic            lo_en,
    output logic            hi_evt,
    output logic            lo_evt
);
    logic hi_now, lo_now, hi_was, lo_was;

    assign hi_now = (fill >= hi_thr);
    assign lo_now = lo_en && (fill <= FW'(lo_thr));
    assign hi_evt = hi_now && !hi_was;
    assign lo_evt = lo_now && !lo_was;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_was <= 1'b0;
            lo_was <= 1'b1;
        end else begin
            hi_was <= hi_now;
            lo_was <= lo_now;
        end
    end
endmodule

// File: rtl/txq_irq.sv
// Sticky interrupt bits; a set event outranks a write-one clear.
module txq_irq #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= evt[i] | (q & ~clr[i]);
        end
        assign flags[i] = q;
    end
endmodule

// File: rtl/txq_ctrl.sv
// Packet sequencer: start trigger, payload accounting, abort handling.
module txq_ctrl
    import pkt_txq_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CRC_W = 3,
    parameter int LO_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             off,
    input  logic             fast_en,
    input  logic [LO_W-1:0]  lo_thr,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [CRC_W-1:0] crc_len,
    input  logic             wr_acc,
    input  logic             fifo_empty,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             pop,
    output logic             done_evt,
    output logic             udr_evt,
    output logic             acc_evt,
    output logic             idle,
    output logic             sending
);
    txq_state_e       state, nstate;
    logic [LEN_W-1:0] payload, wr_cnt, rd_cnt, wr_base;
    logic             pkt_end, wr_inc, fast_go, launch;

    assign payload = (pkt_len > LEN_W'(crc_len)) ? pkt_len - LEN_W'(crc_len) : '0;

    // per-packet write accounting, restarted when a packet ends
    assign pkt_end = (state == ST_FINISH) || (state == ST_FAULT) || (state == ST_SEND && off);
    assign wr_base = pkt_end ? '0 : wr_cnt;
    assign wr_inc  = wr_acc && (wr_base < payload);
    assign acc_evt = wr_inc && ((wr_base + LEN_W'(1)) == payload);
    assign fast_go = fast_en && (wr_cnt > (LEN_W'(lo_thr) + LEN_W'(1)));
    assign launch  = start || fast_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (launch) nstate = (payload == '0) ? ST_FINISH : ST_SEND;
            ST_SEND: begin
                if (off)                         nstate = ST_IDLE;
                else if (tx_ready && fifo_empty) nstate = ST_FAULT;
                else if (pop && tx_last)         nstate = ST_FINISH;
            end
            ST_FINISH: nstate = ST_IDLE;
            ST_FAULT:  nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        done_evt = 1'b0;
        udr_evt  = 1'b0;
        idle     = 1'b0;
        sending  = 1'b0;
        unique case (state)
            ST_IDLE:   idle     = 1'b1;
            ST_SEND: begin
                sending  = 1'b1;
                tx_valid = !off && !fifo_empty;
            end
            ST_FINISH: done_evt = 1'b1;
            ST_FAULT:  udr_evt  = 1'b1;
            default:   idle     = 1'b1;
        endcase
        tx_last = tx_valid && (rd_cnt == payload - LEN_W'(1));
        pop     = tx_valid && tx_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            wr_cnt <= wr_base + LEN_W'(wr_inc);
            if (state != ST_SEND) rd_cnt <= '0;
            else if (pop)         rd_cnt <= rd_cnt + LEN_W'(1);
        end
    end
endmodule

// File: rtl/pkt_txq.sv
module pkt_txq
    import pkt_txq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int LEN_W  = 11,
    parameter int CRC_W  = 3,
    parameter int LO_W   = 6,
    localparam int FW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [FW-1:0]     lvl_hi,
    input  logic [LO_W-1:0]   lvl_lo,
    input  logic              lvl_lo_en,
    input  logic              fast_en,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [CRC_W-1:0]  crc_len,
    input  logic              cmd_start,
    input  logic              cmd_off,
    input  logic              cmd_flush,
    input  logic [IRQ_N-1:0]  irq_clr,
    output logic [IRQ_N-1:0]  irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last
);
    logic [FW-1:0]    fill;
    logic             fifo_empty, fifo_full, wr_acc, pop, flush_go;
    logic             hi_evt, lo_evt, done_evt, udr_evt, acc_evt, ctl_idle, ctl_send;
    logic [IRQ_N-1:0] irq_evt;

    assign flush_go = cmd_flush && ctl_idle;

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_vld), .push_data(wr_byte),
        .pop(pop), .flush(flush_go),
        .pop_data(tx_data), .fill(fill),
        .empty(fifo_empty), .full(fifo_full), .push_ok(wr_acc)
    );

    txq_level #(.FW(FW), .LO_W(LO_W)) u_level (
        .clk(clk), .rst_n(rst_n), .fill(fill),
        .hi_thr(lvl_hi), .lo_thr(lvl_lo), .lo_en(lvl_lo_en),
        .hi_evt(hi_evt), .lo_evt(lo_evt)
    );

    txq_ctrl #(.LEN_W(LEN_W), .CRC_W(CRC_W), .LO_W(LO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(cmd_start), .off(cmd_off), .fast_en(fast_en),
        .lo_thr(lvl_lo), .pkt_len(pkt_len), .crc_len(crc_len),
        .wr_acc(wr_acc), .fifo_empty(fifo_empty), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_last(tx_last), .pop(pop),
        .done_evt(done_evt), .udr_evt(udr_evt), .acc_evt(acc_evt),
        .idle(ctl_idle), .sending(ctl_send)
    );

    always_comb begin
        irq_evt               = '0;
        irq_evt[IRQ_LVL_HI]   = hi_evt;
        irq_evt[IRQ_LVL_LO]   = lo_evt;
        irq_evt[IRQ_DONE]     = done_evt;
        irq_evt[IRQ_ACCEPT]   = acc_evt;
        irq_evt[IRQ_OVERRUN]  = wr_vld && fifo_full;
        irq_evt[IRQ_UNDERRUN] = udr_evt;
    end

    txq_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .clr(irq_clr), .flags(irq)
    );
endmodule

// File: rtl/pkt_txq_chk.sv
module pkt_txq_chk
    import pkt_txq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int FW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_vld,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             tx_last,
    input logic             cmd_off,
    input logic [IRQ_N-1:0] irq,
    input logic [IRQ_N-1:0] irq_clr,
    input logic [FW-1:0]    fill,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             ctl_send
);
    // R2: a byte is offered only when the store holds one
    a_r2_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !fifo_empty);

    // R2: fill count never exceeds depth
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    // R8: last marker only accompanies a valid byte
    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5: write into full store flags overrun
    a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && fifo_full) |=> irq[IRQ_OVERRUN]);

    // R9: final handshake leads to done flag
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> ##1 irq[IRQ_DONE]);

    // R11: request on empty store in SEND leads to underrun flag
    a_r11_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_send && !cmd_off && tx_ready && fifo_empty) |=> ##1 irq[IRQ_UNDERRUN]);

    // R12: uncleared bits stay set
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq & $past(irq & ~irq_clr)) == $past(irq & ~irq_clr)));
endmodule

bind pkt_txq pkt_txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .cmd_off(cmd_off), .irq(irq), .irq_clr(irq_clr),
    .fill(fill), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ctl_send(ctl_send)
);

// File: tb/pkt_txq_test.sv
`timescale 1ns/1ps
module pkt_txq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_vld, lvl_lo_en, fast_en, cmd_start, cmd_off, cmd_flush, tx_ready;
    logic [7:0]  wr_byte;
    logic [6:0]  lvl_hi;
    logic [5:0]  lvl_lo;
    logic [10:0] pkt_len;
    logic [2:0]  crc_len;
    logic [5:0]  irq_clr, irq;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pkt_txq uut (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_byte(wr_byte),
        .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .lvl_lo_en(lvl_lo_en), .fast_en(fast_en),
        .pkt_len(pkt_len), .crc_len(crc_len), .cmd_start(cmd_start), .cmd_off(cmd_off),
        .cmd_flush(cmd_flush), .irq_clr(irq_clr), .irq(irq), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wr_vld = 1'b1; wr_byte = b;
        tick();
        wr_vld = 1'b0;
    endtask

    task automatic clear_all();
        irq_clr = '1; tick(); irq_clr = '0;
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    endtask

    task automatic pulse_flush();
        cmd_flush = 1'b1; tick(); cmd_flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);
    endtask

    task automatic t_basic();
        lvl_lo = 6'd3; lvl_lo_en = 1'b0; pkt_len = 11'd5; crc_len = 3'd2;
        for (int i = 0; i < 5; i++) begin
            wr(8'hA0 + 8'(i));
            if (i == 1) chk("R10 accept early", irq[3], 0);
            if (i == 2) chk("R10 accept at payload", irq[3], 1);
        end
        pulse_start();
        chk("R6 start to SEND", tx_valid, 1);
        tx_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk("R2 order", tx_data, 8'hA0 + 8'(i));
            chk("R8 last marker", tx_last, (i == 2) ? 1 : 0);
            tick();
        end
        chk("R9 done not yet", irq[2], 0);
        tick();
        chk("R9 done flag", irq[2], 1);
        chk("R8 extra bytes held", tx_valid, 0);
        chk("R4 lower alarm disabled", irq[1], 0);
        tx_ready = 1'b0;
        clear_all();
        chk("R12 clear all", irq, 0);
        pulse_flush();
        wr(8'h55);
        pkt_len = 11'd3;
        pulse_start();
        chk("R13 flush emptied", tx_data, 8'h55);
        chk("R8 single byte last", tx_last, 1);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0; tick();
    endtask

    task automatic t_full();
        clear_all();
        lvl_hi = 7'd4; pkt_len = 11'd64; crc_len = 3'd0;
        for (int i = 0; i < 4; i++) wr(8'(i));
        chk("R3 upper alarm due next edge", irq[0], 0);
        tick();
        chk("R3 upper alarm", irq[0], 1);
        irq_clr = 6'b000001; tick(); irq_clr = '0; tick();
        chk("R3 edge only", irq[0], 0);
        for (int i = 4; i < 64; i++) wr(8'(i));
        chk("R5 no overrun yet", irq[4], 0);
        wr(8'hEE);
        chk("R5 overrun flag", irq[4], 1);
        pulse_start();
        tx_ready = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (tx_data !== 8'(i) || tx_last !== (i == 63)) chk("R5 dropped byte absent", {tx_last, tx_data}, {(i == 63), 8'(i)});
            tick();
        end
        chk("R5 store drained", tx_valid, 0);
        tx_ready = 1'b0; tick();
        lvl_hi = 7'd64;
    endtask

    task automatic t_lowmark();
        lvl_lo = 6'd2; lvl_lo_en = 1'b1;
        tick(); tick();
        clear_all(); tick();
        chk("R4 no refire while held", irq[1], 0);
        pkt_len = 11'd5; crc_len = 3'd0;
        for (int i = 0; i < 5; i++) wr(8'hB0 + 8'(i));
        pulse_start();
        tx_ready = 1'b1;
        tick(); tick();
        chk("R4 above level", irq[1], 0);
        tick(); tick(); tick();
        tx_ready = 1'b0; tick();
        chk("R4 lower alarm", irq[1], 1);
        lvl_lo_en = 1'b0;
    endtask

    task automatic t_fast();
        clear_all();
        fast_en = 1'b1; lvl_lo = 6'd3; pkt_len = 11'd10; crc_len = 3'd2;
        for (int i = 0; i < 5; i++) wr(8'hC0 + 8'(i));
        chk("R7 not before trigger edge", tx_valid, 0);
        tick();
        chk("R7 fast start", tx_valid, 1);
        chk("R7 first byte", tx_data, 8'hC0);
        for (int i = 5; i < 8; i++) wr(8'hC0 + 8'(i));
        tx_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            chk("R8 payload byte", tx_data, 8'hC0 + 8'(i));
            chk("R8 payload last", tx_last, (i == 7) ? 1 : 0);
            tick();
        end
        tx_ready = 1'b0; tick();
        chk("R9 done after fast packet", irq[2], 1);
        fast_en = 1'b0;
    endtask

    task automatic t_underrun();
        clear_all();
        pkt_len = 11'd6; crc_len = 3'd0;
        wr(8'hD0); wr(8'hD1);
        pulse_start();
        tx_ready = 1'b1;
        tick(); tick();
        tick();
        chk("R11 underrun due next edge", irq[5], 0);
        tick();
        chk("R11 underrun flag", irq[5], 1);
        chk("R9 no done on abort", irq[2], 0);
        wr(8'h99);
        tick();
        chk("R11 packet aborted", tx_valid, 0);
        tx_ready = 1'b0;
        pulse_flush();
    endtask

    task automatic t_clear_off();
        clear_all();
        pkt_len = 11'd64; crc_len = 3'd0;
        for (int i = 0; i < 64; i++) wr(8'h40 + 8'(i));
        wr_vld = 1'b1; wr_byte = 8'hEE; irq_clr = 6'b010000;
        tick();
        wr_vld = 1'b0; irq_clr = '0;
        chk("R12 event beats clear", irq[4], 1);
        irq_clr = 6'b010000; tick(); irq_clr = '0;
        chk("R12 clear one bit", irq[4], 0);
        pulse_start();
        pulse_flush();
        chk("R13 flush ignored in SEND", tx_valid, 1);
        chk("R13 data kept", tx_data, 8'h40);
        cmd_off = 1'b1; tick(); cmd_off = 1'b0;
        chk("R13 off to IDLE", tx_valid, 0);
        tick();
        chk("R13 no done on off", irq[2], 0);
        pulse_flush();
        wr(8'h77);
        pkt_len = 11'd1;
        pulse_start();
        chk("R13 flush after off", tx_data, 8'h77);
        chk("R8 one-byte last", tx_last, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_vld = 1'b0; wr_byte = '0; lvl_hi = 7'd64; lvl_lo = 6'd3;
        lvl_lo_en = 1'b0; fast_en = 1'b0; pkt_len = '0; crc_len = '0; cmd_start = 1'b0;
        cmd_off = 1'b0; cmd_flush = 1'b0; irq_clr = '0; tx_ready = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_full();
        t_lowmark();
        t_fast();
        t_underrun();
        t_clear_off();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule